// File: doc/BRIEF.md
# Memory-Management Control Register File

This block is a small bank of system-control registers that sits next to a processor core. It holds five registers: a control word, a translation table base, a domain access word, a fault status word and a fault address word. Software reaches them through a coprocessor-style access port. The port picks one register with four selector fields: `cp_crn`, `cp_opc1`, `cp_crm` and `cp_opc2`. A write takes effect at the clock edge. A read returns the selected register combinationally.

The core reports aborts on two strobes, one for instruction fetch and one for data access. Both kinds of abort record a status code and a domain number in the fault status word. Only a data abort records the faulting virtual address in the fault address word.

The control bits (memory-management enable, alignment-check enable and data cache enable) are driven straight from flops. So are the stored translation base field and the domain access word. These outputs feed the core and its memory system.

Top module: `mmu_ctrl_regs`

## Requirements
- R1: A synchronous active-high `rst` clears every register to 0. After reset every read returns 0 and `mmu_en`, `align_chk_en`, `cache_en`, `ttb_base` and `dacr_out` are all 0.
- R2: The control word is selected by CRn=1 with opc1=0, CRm=0 and opc2=0, and only its bits [2:0] are stored. Bit 0 drives `mmu_en`, bit 1 drives `align_chk_en` and bit 2 drives `cache_en`; bits [31:3] read as 0.
- R3: The translation base word is selected by CRn=2 with the other selector fields 0. Bits [31:14] are stored as the base and driven on `ttb_base`, and bits [4:0] are stored as walk attributes. Bits [13:5] read as 0, including the reserved bit 5, and writes to them are ignored.
- R4: The domain access word is selected by CRn=3 with the other selector fields 0. It stores all 32 bits and drives `dacr_out`.
- R5: The fault status word is selected by CRn=5 with the other selector fields 0. Bits [3:0] hold the status and bits [7:4] hold the domain; bits [31:8] read as 0.
- R6: The fault address word is selected by CRn=6 with the other selector fields 0. It stores all 32 bits.
- R7: Any other selector value, including a nonzero opc1, CRm or opc2 with a valid CRn, reads as 0. A write to such a selector changes no register.
- R8: A prefetch abort loads the fault status word with {domain, status} and leaves the fault address word unchanged.
- R9: A data abort loads the fault status word with {domain, status} and loads the fault address word with `dabt_addr`.
- R10: When an abort and a software write hit the same fault register in the same cycle, the abort value is stored.
- R11: When a prefetch abort and a data abort occur in the same cycle, the fault status word takes the data abort's status and domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cp_wr_en | input | 1 | Software write strobe |
| cp_crn | input | 4 | Primary register selector |
| cp_opc1 | input | 3 | First opcode selector |
| cp_crm | input | 4 | Secondary register selector |
| cp_opc2 | input | 3 | Second opcode selector |
| cp_wdata | input | 32 | Write data |
| cp_rdata | output | 32 | Combinational read data of the selected register |
| pabt_valid | input | 1 | Prefetch abort strobe |
| pabt_status | input | 4 | Prefetch abort status code |
| pabt_domain | input | 4 | Prefetch abort domain |
| dabt_valid | input | 1 | Data abort strobe |
| dabt_status | input | 4 | Data abort status code |
| dabt_domain | input | 4 | Data abort domain |
| dabt_addr | input | 32 | Faulting virtual address of a data abort |
| mmu_en | output | 1 | Memory-management enable |
| align_chk_en | output | 1 | Alignment fault checking enable |
| cache_en | output | 1 | Data cache enable |
| ttb_base | output | 18 | Stored translation table base, address bits [31:14] |
| dacr_out | output | 32 | Domain access word |

## Verification
The assertions check several rules on every cycle:
- an unmatched selector always reads 0;
- the gap bits of the translation base word always read 0;
- a control write lands in the next cycle;
- a data abort always lands in the fault address word;
- a prefetch abort alone never disturbs the fault address word.

Some behaviour only the bench's scenarios can show. These are the masking of each register's field layout on readback, and that a write to a near-miss selector leaves every other register intact. They also include the two priority orderings between aborts and software writes, and the full clearing of state by reset.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;
  localparam int NUM_REGS = 5;

  typedef enum logic [2:0] {
    RI_CTRL = 3'd0,
    RI_TTB  = 3'd1,
    RI_DACR = 3'd2,
    RI_FSR  = 3'd3,
    RI_FAR  = 3'd4
  } reg_idx_e;

  // primary selector code for each register slot
  function automatic logic [3:0] crn_code(input int idx);
    case (idx)
      0:       crn_code = 4'd1;
      1:       crn_code = 4'd2;
      2:       crn_code = 4'd3;
      3:       crn_code = 4'd5;
      default: crn_code = 4'd6;
    endcase
  endfunction
endpackage

// File: rtl/mmu_sel_decode.sv
module mmu_sel_decode
  import mmu_regs_pkg::*;
#(
  parameter int NREG = NUM_REGS
) (
  input  logic [3:0]      crn,
  input  logic [2:0]      opc1,
  input  logic [3:0]      crm,
  input  logic [2:0]      opc2,
  output logic [NREG-1:0] hit
);
  logic base_ok;
  assign base_ok = (opc1 == 3'd0) && (crm == 4'd0) && (opc2 == 3'd0);

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign hit[g] = base_ok && (crn == crn_code(g));
  end
endmodule

// File: rtl/mmu_cfg_regs.sv
module mmu_cfg_regs #(
  parameter int DATA_W     = 32,
  parameter int CTRL_W     = 3,
  parameter int TTB_LSB    = 14,
  parameter int TTB_ATTR_W = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_ctrl,
  input  logic                      wr_ttb,
  input  logic                      wr_dacr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [CTRL_W-1:0]         ctrl_q,
  output logic [DATA_W-TTB_LSB-1:0] ttb_base_q,
  output logic [TTB_ATTR_W-1:0]     ttb_attr_q,
  output logic [DATA_W-1:0]         dacr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      ttb_base_q <= '0;
      ttb_attr_q <= '0;
      dacr_q     <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
      if (wr_ttb) begin
        ttb_base_q <= wdata[DATA_W-1:TTB_LSB];
        ttb_attr_q <= wdata[TTB_ATTR_W-1:0];
      end
      if (wr_dacr) dacr_q <= wdata;
    end
  end

  AST_CTRL_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> ctrl_q == $past(wdata[CTRL_W-1:0])); // R2
  AST_DACR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_dacr |=> $stable(dacr_q)); // R4
endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs #(
  parameter int DATA_W = 32,
  parameter int FS_W   = 4,
  parameter int DOM_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_fsr,
  input  logic                  wr_far,
  input  logic [DATA_W-1:0]     wdata,
  input  logic                  pabt_valid,
  input  logic [FS_W-1:0]       pabt_status,
  input  logic [DOM_W-1:0]      pabt_domain,
  input  logic                  dabt_valid,
  input  logic [FS_W-1:0]       dabt_status,
  input  logic [DOM_W-1:0]      dabt_domain,
  input  logic [DATA_W-1:0]     dabt_addr,
  output logic [FS_W+DOM_W-1:0] fsr_q,
  output logic [DATA_W-1:0]     far_q
);
  localparam int FSR_W = FS_W + DOM_W;

  logic [FSR_W-1:0] abort_word;
  always_comb begin
    // data abort outranks prefetch abort
    if (dabt_valid) abort_word = {dabt_domain, dabt_status};
    else            abort_word = {pabt_domain, pabt_status};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsr_q <= '0;
      far_q <= '0;
    end else begin
      if (dabt_valid || pabt_valid) fsr_q <= abort_word;
      else if (wr_fsr)              fsr_q <= wdata[FSR_W-1:0];
      if (dabt_valid)               far_q <= dabt_addr;
      else if (wr_far)              far_q <= wdata;
    end
  end

  AST_FAR_KEEP_ON_PABT: assert property (@(posedge clk) disable iff (rst)
    (pabt_valid && !dabt_valid && !wr_far) |=> $stable(far_q)); // R8
  AST_FAR_DABT_LOAD: assert property (@(posedge clk) disable iff (rst)
    dabt_valid |=> far_q == $past(dabt_addr)); // R9
  AST_FSR_ABORT_WINS: assert property (@(posedge clk) disable iff (rst)
    (dabt_valid && wr_fsr) |=> fsr_q == $past({dabt_domain, dabt_status})); // R10
  AST_FSR_DABT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (dabt_valid && pabt_valid) |=> fsr_q[FS_W-1:0] == $past(dabt_status)); // R11
endmodule

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs
  import mmu_regs_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CTRL_W     = 3,
  parameter int TTB_LSB    = 14,
  parameter int TTB_ATTR_W = 5,
  parameter int FS_W       = 4,
  parameter int DOM_W      = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cp_wr_en,
  input  logic [3:0]                cp_crn,
  input  logic [2:0]                cp_opc1,
  input  logic [3:0]                cp_crm,
  input  logic [2:0]                cp_opc2,
  input  logic [DATA_W-1:0]         cp_wdata,
  output logic [DATA_W-1:0]         cp_rdata,
  input  logic                      pabt_valid,
  input  logic [FS_W-1:0]           pabt_status,
  input  logic [DOM_W-1:0]          pabt_domain,
  input  logic                      dabt_valid,
  input  logic [FS_W-1:0]           dabt_status,
  input  logic [DOM_W-1:0]          dabt_domain,
  input  logic [DATA_W-1:0]         dabt_addr,
  output logic                      mmu_en,
  output logic                      align_chk_en,
  output logic                      cache_en,
  output logic [DATA_W-TTB_LSB-1:0] ttb_base,
  output logic [DATA_W-1:0]         dacr_out
);
  localparam int BASE_W = DATA_W - TTB_LSB;
  localparam int FSR_W  = FS_W + DOM_W;

  logic [NUM_REGS-1:0] hit;
  logic [NUM_REGS-1:0] wr;
  logic [CTRL_W-1:0]     ctrl_q;
  logic [BASE_W-1:0]     base_q;
  logic [TTB_ATTR_W-1:0] attr_q;
  logic [DATA_W-1:0]     dacr_q;
  logic [FSR_W-1:0]      fsr_q;
  logic [DATA_W-1:0]     far_q;
  logic [DATA_W-1:0]     view [NUM_REGS];

  mmu_sel_decode #(.NREG(NUM_REGS)) i_dec (
    .crn(cp_crn), .opc1(cp_opc1), .crm(cp_crm), .opc2(cp_opc2), .hit(hit)
  );

  assign wr = hit & {NUM_REGS{cp_wr_en}};

  mmu_cfg_regs #(
    .DATA_W(DATA_W), .CTRL_W(CTRL_W), .TTB_LSB(TTB_LSB), .TTB_ATTR_W(TTB_ATTR_W)
  ) i_cfg (
    .clk(clk), .rst(rst),
    .wr_ctrl(wr[RI_CTRL]), .wr_ttb(wr[RI_TTB]), .wr_dacr(wr[RI_DACR]),
    .wdata(cp_wdata),
    .ctrl_q(ctrl_q), .ttb_base_q(base_q), .ttb_attr_q(attr_q), .dacr_q(dacr_q)
  );

  mmu_fault_regs #(.DATA_W(DATA_W), .FS_W(FS_W), .DOM_W(DOM_W)) i_flt (
    .clk(clk), .rst(rst),
    .wr_fsr(wr[RI_FSR]), .wr_far(wr[RI_FAR]), .wdata(cp_wdata),
    .pabt_valid(pabt_valid), .pabt_status(pabt_status), .pabt_domain(pabt_domain),
    .dabt_valid(dabt_valid), .dabt_status(dabt_status), .dabt_domain(dabt_domain),
    .dabt_addr(dabt_addr),
    .fsr_q(fsr_q), .far_q(far_q)
  );

  // zero-extended read views, gaps and reserved bits forced to 0
  always_comb begin
    view[RI_CTRL] = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
    view[RI_TTB]  = {base_q, {(TTB_LSB-TTB_ATTR_W){1'b0}}, attr_q};
    view[RI_DACR] = dacr_q;
    view[RI_FSR]  = {{(DATA_W-FSR_W){1'b0}}, fsr_q};
    view[RI_FAR]  = far_q;
  end

  always_comb begin
    cp_rdata = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (hit[i]) cp_rdata = cp_rdata | view[i];
  end

  assign mmu_en       = ctrl_q[0];
  assign align_chk_en = ctrl_q[1];
  assign cache_en     = ctrl_q[2];
  assign ttb_base     = base_q;
  assign dacr_out     = dacr_q;

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (hit == '0) |-> (cp_rdata == '0)); // R7
  AST_TTB_GAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    hit[RI_TTB] |-> (cp_rdata[TTB_LSB-1:TTB_ATTR_W] == '0)); // R3
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit)); // R7
endmodule

// File: tb/test_mmu_ctrl_regs.sv
module test_mmu_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cp_wr_en = 1'b0;
  logic [3:0]  cp_crn = '0;
  logic [2:0]  cp_opc1 = '0;
  logic [3:0]  cp_crm = '0;
  logic [2:0]  cp_opc2 = '0;
  logic [31:0] cp_wdata = '0;
  logic [31:0] cp_rdata;
  logic        pabt_valid = 1'b0;
  logic [3:0]  pabt_status = '0, pabt_domain = '0;
  logic        dabt_valid = 1'b0;
  logic [3:0]  dabt_status = '0, dabt_domain = '0;
  logic [31:0] dabt_addr = '0;
  logic        mmu_en, align_chk_en, cache_en;
  logic [17:0] ttb_base;
  logic [31:0] dacr_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mmu_ctrl_regs i_mmu_ctrl_regs (
    .clk(clk), .rst(rst), .cp_wr_en(cp_wr_en),
    .cp_crn(cp_crn), .cp_opc1(cp_opc1), .cp_crm(cp_crm), .cp_opc2(cp_opc2),
    .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
    .pabt_valid(pabt_valid), .pabt_status(pabt_status), .pabt_domain(pabt_domain),
    .dabt_valid(dabt_valid), .dabt_status(dabt_status), .dabt_domain(dabt_domain),
    .dabt_addr(dabt_addr),
    .mmu_en(mmu_en), .align_chk_en(align_chk_en), .cache_en(cache_en),
    .ttb_base(ttb_base), .dacr_out(dacr_out)
  );

  typedef struct packed {
    logic [3:0]  crn;
    logic [2:0]  o1;
    logic [3:0]  crm;
    logic [2:0]  o2;
    logic [31:0] wd;
    logic [31:0] rx;
  } vec_t;

  // write then read back through the same selector
  localparam vec_t VECS [8] = '{
    '{4'd1, 3'd0, 4'd0, 3'd0, 32'hFFFF_FFFF, 32'h0000_0007}, // R2 upper bits masked
    '{4'd1, 3'd0, 4'd0, 3'd0, 32'h0000_0005, 32'h0000_0005}, // R2
    '{4'd2, 3'd0, 4'd0, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_C01F}, // R3 gap incl. bit 5
    '{4'd2, 3'd0, 4'd0, 3'd0, 32'h1234_5FE0, 32'h1234_4000}, // R3
    '{4'd3, 3'd0, 4'd0, 3'd0, 32'hA5A5_0F0F, 32'hA5A5_0F0F}, // R4
    '{4'd5, 3'd0, 4'd0, 3'd0, 32'hFFFF_FFFF, 32'h0000_00FF}, // R5
    '{4'd6, 3'd0, 4'd0, 3'd0, 32'hDEAD_BEEF, 32'hDEAD_BEEF}, // R6
    '{4'd4, 3'd0, 4'd0, 3'd0, 32'h1111_1111, 32'h0000_0000}  // R7
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic sel(input logic [3:0] crn, input logic [2:0] o1,
                     input logic [3:0] crm, input logic [2:0] o2);
    cp_crn = crn; cp_opc1 = o1; cp_crm = crm; cp_opc2 = o2;
  endtask

  // drive at negedge, commit at posedge, release at next negedge
  task automatic wr_reg(input logic [3:0] crn, input logic [2:0] o1,
                        input logic [3:0] crm, input logic [2:0] o2, input logic [31:0] d);
    @(negedge clk);
    sel(crn, o1, crm, o2);
    cp_wdata = d; cp_wr_en = 1'b1;
    @(negedge clk);
    cp_wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] crn, input logic [2:0] o1,
                        input logic [3:0] crm, input logic [2:0] o2, output logic [31:0] d);
    sel(crn, o1, crm, o2);
    #1 d = cp_rdata;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int c = 1; c <= 6; c++) begin
      rd_reg(c[3:0], 3'd0, 4'd0, 3'd0, r);
      check("R1 read", r, 32'h0);
    end
    check("R1 outs", {mmu_en, align_chk_en, cache_en, ttb_base != 0, dacr_out != 0}, 32'h0);

    for (int k = 0; k < 8; k++) begin
      wr_reg(VECS[k].crn, VECS[k].o1, VECS[k].crm, VECS[k].o2, VECS[k].wd);
      rd_reg(VECS[k].crn, VECS[k].o1, VECS[k].crm, VECS[k].o2, r);
      check($sformatf("vec%0d", k), r, VECS[k].rx);
    end

    // R2: control bits on outputs (bit0 mmu, bit1 align, bit2 cache, value 5)
    check("R2 outs", {29'd0, cache_en, align_chk_en, mmu_en}, 32'h5);
    // R3: stored base on output
    check("R3 base", {14'd0, ttb_base}, 32'h0000_48D1);
    // R4
    check("R4 out", dacr_out, 32'hA5A5_0F0F);

    // R7: near-miss selectors ignore writes and read 0
    wr_reg(4'd1, 3'd0, 4'd0, 3'd1, 32'h0);
    wr_reg(4'd3, 3'd1, 4'd0, 3'd0, 32'h0);
    wr_reg(4'd6, 3'd0, 4'd1, 3'd0, 32'h0);
    rd_reg(4'd1, 3'd0, 4'd0, 3'd0, r); check("R7 ctrl kept", r, 32'h5);
    rd_reg(4'd3, 3'd0, 4'd0, 3'd0, r); check("R7 dacr kept", r, 32'hA5A5_0F0F);
    rd_reg(4'd6, 3'd0, 4'd0, 3'd0, r); check("R7 far kept", r, 32'hDEAD_BEEF);
    rd_reg(4'd1, 3'd0, 4'd0, 3'd1, r); check("R7 miss read", r, 32'h0);

    // R8: prefetch abort -> FSR {9,3}, FAR unchanged
    @(negedge clk);
    pabt_valid = 1'b1; pabt_status = 4'h3; pabt_domain = 4'h9;
    @(negedge clk);
    pabt_valid = 1'b0;
    rd_reg(4'd5, 3'd0, 4'd0, 3'd0, r); check("R8 fsr", r, 32'h93);
    rd_reg(4'd6, 3'd0, 4'd0, 3'd0, r); check("R8 far", r, 32'hDEAD_BEEF);

    // R9: data abort
    @(negedge clk);
    dabt_valid = 1'b1; dabt_status = 4'h5; dabt_domain = 4'h2; dabt_addr = 32'h1000_0004;
    @(negedge clk);
    dabt_valid = 1'b0;
    rd_reg(4'd5, 3'd0, 4'd0, 3'd0, r); check("R9 fsr", r, 32'h25);
    rd_reg(4'd6, 3'd0, 4'd0, 3'd0, r); check("R9 far", r, 32'h1000_0004);

    // R10: abort beats same-cycle software write (FAR, then FSR)
    @(negedge clk);
    sel(4'd6, 3'd0, 4'd0, 3'd0); cp_wdata = 32'h0; cp_wr_en = 1'b1;
    dabt_valid = 1'b1; dabt_status = 4'hA; dabt_domain = 4'h7; dabt_addr = 32'h2222_3333;
    @(negedge clk);
    cp_wr_en = 1'b0; dabt_valid = 1'b0;
    rd_reg(4'd6, 3'd0, 4'd0, 3'd0, r); check("R10 far", r, 32'h2222_3333);
    @(negedge clk);
    sel(4'd5, 3'd0, 4'd0, 3'd0); cp_wdata = 32'h0; cp_wr_en = 1'b1;
    pabt_valid = 1'b1; pabt_status = 4'hC; pabt_domain = 4'h4;
    @(negedge clk);
    cp_wr_en = 1'b0; pabt_valid = 1'b0;
    rd_reg(4'd5, 3'd0, 4'd0, 3'd0, r); check("R10 fsr", r, 32'h4C);

    // R11: both aborts, data abort wins the status word
    @(negedge clk);
    pabt_valid = 1'b1; pabt_status = 4'h1; pabt_domain = 4'h1;
    dabt_valid = 1'b1; dabt_status = 4'hE; dabt_domain = 4'hB; dabt_addr = 32'h0000_ABCD;
    @(negedge clk);
    pabt_valid = 1'b0; dabt_valid = 1'b0;
    rd_reg(4'd5, 3'd0, 4'd0, 3'd0, r); check("R11 fsr", r, 32'hBE);
    rd_reg(4'd6, 3'd0, 4'd0, 3'd0, r); check("R11 far", r, 32'h0000_ABCD);

    // R1: reset clears again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd_reg(4'd1, 3'd0, 4'd0, 3'd0, r); check("R1 ctrl", r, 32'h0);
    rd_reg(4'd6, 3'd0, 4'd0, 3'd0, r); check("R1 far", r, 32'h0);
    check("R1 mmu_en", {31'd0, mmu_en}, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule